// File: doc/BRIEF.md
# Fractional Clock Divider Control Register Bank

This block holds the settings for four independent fractional clock dividers in a single 32-bit control word. Each divider owns one 8-bit slice of the word. The low six bits of a slice give the fraction value. The top bit of a slice is a gate bit with inverted polarity: when it is 1 the divider's clock is stopped. The divider's output frequency is its input frequency multiplied by 18 and divided by the fraction value. Bit 6 of each slice is reserved.

Software reaches the word through a plain register port with a word offset, write data, a write strobe and read data. Offset 0 loads the whole word. The other three offsets are atomic aliases: one ORs the write data into the word, one clears the bits that are set in the write data, and one inverts them. A driver can therefore change one divider's slice without a read-modify-write.

The block decodes every slice into a fraction output, an active-high enable and a range flag. The range flag marks any fraction that lies outside the legal span of 12 to 35 inclusive. All ports are plain control and status pins, and no valid/ready handshake applies. A write takes effect at the clock edge on which `we_i` is high.

Top module: `fracclk_ctrl_bank`

## Requirements
- R1: After reset the word reads 0x92929292. Every gate bit is 1, every enable is low, every fraction is 18 and no range flag is raised.
- R2: A write at offset 0 replaces the word with the write data, except for the reserved bits.
- R3: A write at offset 1 ORs the write data into the word.
- R4: A write at offset 2 clears every word bit that is 1 in the write data.
- R5: A write at offset 3 inverts every word bit that is 1 in the write data.
- R6: Bit 6 of every slice (word bits 6, 14, 22 and 30) always reads 0, whatever any write puts there.
- R7: `rdata_o` always shows the current word, and the offset does not affect it.
- R8: `clk_en_o[n]` is the inverse of word bit 8n+7.
- R9: `frac_o[6n+5:6n]` equals word bits [8n+5:8n].
- R10: `range_err_o[n]` is 1 exactly when fraction n is below 12 or above 35. The values 12 and 35 are legal.
- R11: While `we_i` is low the word does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Word offset: 0 load, 1 set, 2 clear, 3 toggle |
| wdata_i | input | 32 | Write data or bit mask |
| we_i | input | 1 | Write strobe |
| rdata_o | output | 32 | Current control word |
| frac_o | output | 24 | Four 6-bit fraction values, divider n at [6n+5:6n] |
| clk_en_o | output | 4 | Per-divider clock enable, active high |
| range_err_o | output | 4 | Per-divider fraction out-of-range flag |

## Verification
The write-unit properties compare the word after a write with the word and write data sampled one cycle earlier. They therefore assume that `addr_i` and `wdata_i` are stable, known values whenever `we_i` is high. The bench meets this by driving all inputs on the falling edge and holding them through the following rising edge. Stimulus is a directed pass followed by pseudo-random writes and idle cycles. The directed pass covers fractions 0, 11, 12, 35, 36 and 63, and write data with the reserved bits set. The random pass mixes all four offsets.

// File: rtl/fracclk_pkg.sv
package fracclk_pkg;
  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_TOG  = 2'd3
  } wr_op_e;
endpackage

// File: rtl/fracclk_wr_unit.sv
module fracclk_wr_unit
  import fracclk_pkg::*;
#(
  parameter int NUM_DIV  = 4,
  parameter int FIELD_W  = 8,
  parameter int FRAC_W   = 6,
  parameter int FRAC_RST = 18,
  localparam int DATA_W  = NUM_DIV * FIELD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wr_op_e            op_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] word_o
);
  logic [DATA_W-1:0] keep_mask;
  logic [DATA_W-1:0] rst_word;
  logic [DATA_W-1:0] word_q, word_d;

  // Implemented bits: fraction bits and gate bit of each slice.
  for (genvar n = 0; n < NUM_DIV; n++) begin : g_mask
    for (genvar b = 0; b < FIELD_W; b++) begin : g_bit
      if (b < FRAC_W || b == FIELD_W - 1) begin : g_live
        assign keep_mask[n*FIELD_W+b] = 1'b1;
        if (b == FIELD_W - 1) begin : g_gate
          assign rst_word[n*FIELD_W+b] = 1'b1;
        end else begin : g_frac
          assign rst_word[n*FIELD_W+b] = FRAC_RST[b];
        end
      end else begin : g_rsvd
        assign keep_mask[n*FIELD_W+b] = 1'b0;
        assign rst_word[n*FIELD_W+b]  = 1'b0;
      end
    end
  end

  always_comb begin
    unique case (op_i)
      OP_LOAD: word_d = wdata_i;
      OP_SET:  word_d = word_q | wdata_i;
      OP_CLR:  word_d = word_q & ~wdata_i;
      OP_TOG:  word_d = word_q ^ wdata_i;
      default: word_d = word_q;
    endcase
    word_d = word_d & keep_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word_q <= rst_word;
    else if (we_i) word_q <= word_d;
  end

  assign word_o = word_q;

  p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(word_q));
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && op_i == OP_LOAD) |=> word_q == ($past(wdata_i) & keep_mask));
  p_set_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && op_i == OP_SET) |=>
      ((word_q & $past(wdata_i) & keep_mask) == ($past(wdata_i) & keep_mask)));
  p_clr_zeros_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && op_i == OP_CLR) |=> ((word_q & $past(wdata_i)) == '0));
  p_tog_flips_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && op_i == OP_TOG) |=>
      ((word_q ^ $past(word_q)) == ($past(wdata_i) & keep_mask)));
endmodule

// File: rtl/fracclk_field.sv
module fracclk_field #(
  parameter int FRAC_W   = 6,
  parameter int FRAC_MIN = 12,
  parameter int FRAC_MAX = 35
) (
  input  logic [FRAC_W-1:0] frac_i,
  input  logic              gate_i,
  output logic [FRAC_W-1:0] frac_o,
  output logic              en_o,
  output logic              range_err_o
);
  localparam logic [FRAC_W-1:0] LoLim = FRAC_W'(FRAC_MIN);
  localparam logic [FRAC_W-1:0] HiLim = FRAC_W'(FRAC_MAX);

  assign frac_o      = frac_i;
  assign en_o        = ~gate_i;
  assign range_err_o = (frac_i < LoLim) || (frac_i > HiLim);
endmodule

// File: rtl/fracclk_ctrl_bank.sv
module fracclk_ctrl_bank
  import fracclk_pkg::*;
#(
  parameter int NUM_DIV  = 4,
  parameter int FIELD_W  = 8,
  parameter int FRAC_W   = 6,
  parameter int FRAC_MIN = 12,
  parameter int FRAC_MAX = 35,
  parameter int FRAC_RST = 18,
  localparam int DATA_W  = NUM_DIV * FIELD_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic                     we_i,
  output logic [DATA_W-1:0]        rdata_o,
  output logic [NUM_DIV*FRAC_W-1:0] frac_o,
  output logic [NUM_DIV-1:0]       clk_en_o,
  output logic [NUM_DIV-1:0]       range_err_o
);
  logic [DATA_W-1:0] word;

  fracclk_wr_unit #(
    .NUM_DIV (NUM_DIV),
    .FIELD_W (FIELD_W),
    .FRAC_W  (FRAC_W),
    .FRAC_RST(FRAC_RST)
  ) u_wr (
    .clk    (clk),
    .rst_n  (rst_n),
    .op_i   (wr_op_e'(addr_i)),
    .wdata_i(wdata_i),
    .we_i   (we_i),
    .word_o (word)
  );

  assign rdata_o = word;

  for (genvar n = 0; n < NUM_DIV; n++) begin : g_div
    fracclk_field #(
      .FRAC_W  (FRAC_W),
      .FRAC_MIN(FRAC_MIN),
      .FRAC_MAX(FRAC_MAX)
    ) u_field (
      .frac_i     (word[n*FIELD_W +: FRAC_W]),
      .gate_i     (word[n*FIELD_W + FIELD_W - 1]),
      .frac_o     (frac_o[n*FRAC_W +: FRAC_W]),
      .en_o       (clk_en_o[n]),
      .range_err_o(range_err_o[n])
    );

    p_legal_no_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(frac_o[n*FRAC_W +: FRAC_W]) >= FRAC_MIN &&
       int'(frac_o[n*FRAC_W +: FRAC_W]) <= FRAC_MAX) |-> !range_err_o[n]);
    p_gate_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rdata_o[n*FIELD_W + FIELD_W - 1] |-> !clk_en_o[n]);
  end
endmodule

// File: tb/fracclk_ctrl_bank_test.sv
`timescale 1ns/1ps
module fracclk_ctrl_bank_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  addr_i;
  logic [31:0] wdata_i;
  logic        we_i;
  logic [31:0] rdata_o;
  logic [23:0] frac_o;
  logic [3:0]  clk_en_o;
  logic [3:0]  range_err_o;

  int compared = 0;
  int mismatched = 0;
  logic [31:0] model;
  bit done = 0;

  always #5 clk = ~clk;

  fracclk_ctrl_bank uut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wdata_i(wdata_i),
    .we_i(we_i), .rdata_o(rdata_o), .frac_o(frac_o),
    .clk_en_o(clk_en_o), .range_err_o(range_err_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check(req, rdata_o, model);
    check("R6", {28'd0, rdata_o[30], rdata_o[22], rdata_o[14], rdata_o[6]}, 32'd0);
    for (int n = 0; n < 4; n++) begin
      int f;
      f = model[8*n +: 6];
      check("R9", {26'd0, frac_o[6*n +: 6]}, f);
      check("R8", {31'd0, clk_en_o[n]}, {31'd0, ~model[8*n+7]});
      check("R10", {31'd0, range_err_o[n]}, {31'd0, (f < 12 || f > 35)});
    end
  endtask

  // Behavioural reference: one write or idle cycle, compared afterwards.
  task automatic step(input logic we, input logic [1:0] a, input logic [31:0] d);
    string req;
    logic [31:0] nxt;
    we_i = we; addr_i = a; wdata_i = d;
    @(posedge clk);
    nxt = model;
    if (we) begin
      if (a == 2'd0) begin nxt = d; req = "R2"; end
      else if (a == 2'd1) begin nxt = model | d; req = "R3"; end
      else if (a == 2'd2) begin nxt = model & ~d; req = "R4"; end
      else begin nxt = model ^ d; req = "R5"; end
    end else req = "R11";
    model = nxt & 32'hBFBFBFBF;
    @(negedge clk);
    check_all(req);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; we_i = 1'b0; addr_i = 2'd0; wdata_i = '0;
    model = 32'h92929292;
    repeat (3) @(negedge clk);
    check_all("R1");
    check("R1", {28'd0, clk_en_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");
    // R2 load with reserved bits set and boundary fractions 11,12,35,36
    step(1, 2'd0, 32'h64634C4B);
    step(1, 2'd0, 32'hE3CC2B0B);
    // R7 reads at every offset while idle
    for (int a = 0; a < 4; a++) step(0, a[1:0], 32'hFFFFFFFF);
    // R3 set gate of divider 1, fraction bits on divider 0 (63)
    step(1, 2'd1, 32'h0000BF3F);
    // R4 clear gates and fraction of divider 2 to 0
    step(1, 2'd2, 32'h80BF8080);
    // R5 toggle gates and low fraction bits
    step(1, 2'd3, 32'hC1C08001);
    step(1, 2'd3, 32'h80808080);
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] | r[1], r[3:2], $urandom);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule